// File: doc/BRIEF.md
# Register Stack Frame Renamer

This block translates logical general-register numbers into physical register numbers for a processor whose upper register range is organised as a stack of procedure frames. Logical registers 0 to 31 are shared by every procedure and pass straight through. Logical registers 32 to 127 form a 96-entry window. The window is placed over a circular physical file of at least 96 entries, starting at a movable base slot.

Each frame is made of a local area followed by an output area, and an allocate command sets both sizes. A call slides the window forward past the caller's locals, so that the caller's first output register is seen by the callee as logical 32. The caller's frame is pushed onto a small saved-frame stack, and a return pops it back. The block counts how many physical registers are held by suspended callers. When those registers plus the current frame no longer fit in the physical file, it raises a spill request for a separate save engine to act on. A lookup of a stacked register outside the current frame is flagged as illegal.

Top module: `rsf_renamer`

## Requirements
- R1: A logical register below 32 maps to the physical register of the same number and is never flagged illegal.
- R2: A logical register n of 32 or more maps to physical 32 + ((base + n - 32) mod PHYS_STACKED), where base is the current frame base slot. The mapping wraps around the physical stacked file.
- R3: A lookup of logical register n of 32 or more drives rd_illegal high exactly when n - 32 is greater than or equal to the current frame size.
- R4: A command is accepted only while cmd_valid is high. Operation codes on cmd_op are 0 none, 1 allocate, 2 call and 3 return. An accepted allocate with locals L and outputs O sets the frame size to L + O and the local size to L. While cmd_valid is low, the frame state does not change.
- R5: An allocate whose L + O exceeds 96 is rejected: cmd_err is raised and the frame state is unchanged. A total of exactly 96 is accepted.
- R6: A call pushes the current frame and sets the new base to (base + locals) mod PHYS_STACKED. It sets the new frame size to the old frame size minus the locals, and the new local size to 0.
- R7: A return restores the base, frame size and local size of the most recently pushed frame. A return with no saved frame raises cmd_err and changes nothing.
- R8: A call while the saved-frame stack already holds SAVE_DEPTH frames raises cmd_err and changes nothing.
- R9: spill_req is high exactly while the locals of all saved frames plus the current frame size exceed PHYS_STACKED.
- R10: After reset, base, frame size and local size are 0, and cmd_err and spill_req are low.
- R11: cmd_err is high for exactly the one cycle after a rejected command and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation: 0 none, 1 allocate, 2 call, 3 return |
| cmd_locals | input | 7 | Local area size for allocate |
| cmd_outs | input | 7 | Output area size for allocate |
| rd_lreg | input | 7 | Logical register to translate |
| rd_preg | output | PREG_W (7) | Physical register number |
| rd_illegal | output | 1 | Stacked register outside the current frame |
| cur_base | output | BASE_W (7) | Current frame base slot |
| cur_sof | output | 7 | Current frame size |
| cur_sol | output | 7 | Current local size |
| cmd_err | output | 1 | Rejected-command pulse |
| spill_req | output | 1 | Physical stacked file oversubscribed |

## Verification
Translation is combinational from the current frame state, so rd_preg and rd_illegal are valid in the same cycle that rd_lreg is driven. Frame state, spill_req and cmd_err all move on the first rising edge after a command is presented. The bench drives every command on a falling edge and samples every result on the next falling edge. Each check therefore sees exactly one register stage between stimulus and result. The saved-frame stack limit and the stacked-window wrap are reached through the command sequence itself, not by preloading state.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
   localparam int unsigned GLOBAL_REGS = 32;
   localparam int unsigned WINDOW_REGS = 96;
   localparam int unsigned LREG_W      = 7;
   localparam int unsigned CNT_W       = 7;

   typedef enum logic [1:0] {
      OP_NOP   = 2'd0,
      OP_ALLOC = 2'd1,
      OP_CALL  = 2'd2,
      OP_RET   = 2'd3
   } rsf_op_e;
endpackage

// File: rtl/rsf_frame_stack.sv
module rsf_frame_stack #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 21,
   localparam int unsigned PTR_W = $clog2(DEPTH + 1),
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] push_data,
   output logic [W-1:0] top_data,
   output logic         full,
   output logic         empty
);
   logic [PTR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (push) cnt_q <= cnt_q + PTR_W'(1);
      else if (pop)  cnt_q <= cnt_q - PTR_W'(1);
   end

   assign full  = (cnt_q == PTR_W'(DEPTH));
   assign empty = (cnt_q == '0);

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (push) slot_q <= push_data;
         end
         assign top_data = slot_q;
      end else begin : g_array
         logic [W-1:0]     mem_q [DEPTH];
         logic [PTR_W-1:0] top_ptr;
         assign top_ptr = cnt_q - PTR_W'(1);
         always_ff @(posedge clk) begin
            if (push) mem_q[cnt_q[IDX_W-1:0]] <= push_data;
         end
         assign top_data = mem_q[top_ptr[IDX_W-1:0]];
      end
   endgenerate
endmodule

// File: rtl/rsf_map.sv
module rsf_map import rsf_pkg::*; #(
   parameter int unsigned PHYS   = 96,
   parameter int unsigned BASE_W = 7,
   parameter int unsigned PREG_W = 7,
   localparam int unsigned SUM_W = ((BASE_W > LREG_W) ? BASE_W : LREG_W) + 1
) (
   input  logic [LREG_W-1:0] lreg,
   input  logic [BASE_W-1:0] base,
   input  logic [CNT_W-1:0]  sof,
   output logic [PREG_W-1:0] preg,
   output logic              illegal
);
   logic              is_global;
   logic [LREG_W-1:0] off;
   logic [SUM_W-1:0]  sum;
   logic [SUM_W-1:0]  slot;

   assign is_global = (lreg < LREG_W'(GLOBAL_REGS));
   assign off       = lreg - LREG_W'(GLOBAL_REGS);
   assign sum       = SUM_W'(base) + SUM_W'(off);

   generate
      if ((PHYS & (PHYS - 1)) == 0) begin : g_mask
         assign slot = sum & SUM_W'(PHYS - 1);
      end else begin : g_sub
         assign slot = (sum >= SUM_W'(PHYS)) ? (sum - SUM_W'(PHYS)) : sum;
      end
   endgenerate

   assign preg    = is_global ? PREG_W'(lreg) : (PREG_W'(slot) + PREG_W'(GLOBAL_REGS));
   assign illegal = !is_global && (off >= sof);
endmodule

// File: rtl/rsf_renamer.sv
module rsf_renamer import rsf_pkg::*; #(
   parameter int unsigned PHYS_STACKED = 96,
   parameter int unsigned SAVE_DEPTH   = 4,
   localparam int unsigned BASE_W = $clog2(PHYS_STACKED),
   localparam int unsigned PREG_W = $clog2(GLOBAL_REGS + PHYS_STACKED),
   localparam int unsigned HELD_W = $clog2((SAVE_DEPTH + 1) * WINDOW_REGS + 1),
   localparam int unsigned SUM_W  = ((BASE_W > CNT_W) ? BASE_W : CNT_W) + 1,
   localparam int unsigned FRM_W  = BASE_W + 2 * CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [CNT_W-1:0]  cmd_locals,
   input  logic [CNT_W-1:0]  cmd_outs,
   input  logic [LREG_W-1:0] rd_lreg,
   output logic [PREG_W-1:0] rd_preg,
   output logic              rd_illegal,
   output logic [BASE_W-1:0] cur_base,
   output logic [CNT_W-1:0]  cur_sof,
   output logic [CNT_W-1:0]  cur_sol,
   output logic              cmd_err,
   output logic              spill_req
);
   generate
      if (PHYS_STACKED < WINDOW_REGS) begin : g_bad_phys
         $error("PHYS_STACKED must cover the 96-entry window");
      end
      if ((PHYS_STACKED % 16) != 0) begin : g_bad_step
         $error("PHYS_STACKED must be a multiple of 16");
      end
      if (SAVE_DEPTH < 1) begin : g_bad_depth
         $error("SAVE_DEPTH must be at least 1");
      end
   endgenerate

   logic [BASE_W-1:0] base_q, base_d;
   logic [CNT_W-1:0]  sof_q, sof_d, sol_q, sol_d;
   logic [HELD_W-1:0] held_q, held_d;
   logic              err_q, err_d;

   logic              do_alloc, do_call, do_ret, alloc_ok;
   logic              stk_push, stk_pop, stk_full, stk_empty;
   logic [CNT_W:0]    req_total;
   logic [SUM_W-1:0]  call_sum;
   logic [FRM_W-1:0]  push_frame, top_frame;
   logic [BASE_W-1:0] pop_base;
   logic [CNT_W-1:0]  pop_sof, pop_sol;

   assign do_alloc  = cmd_valid && (cmd_op == OP_ALLOC);
   assign do_call   = cmd_valid && (cmd_op == OP_CALL);
   assign do_ret    = cmd_valid && (cmd_op == OP_RET);
   assign req_total = (CNT_W+1)'(cmd_locals) + (CNT_W+1)'(cmd_outs);
   assign alloc_ok  = (req_total <= (CNT_W+1)'(WINDOW_REGS));
   assign stk_push  = do_call && !stk_full;
   assign stk_pop   = do_ret && !stk_empty;

   assign push_frame = {base_q, sof_q, sol_q};
   assign {pop_base, pop_sof, pop_sol} = top_frame;
   assign call_sum   = SUM_W'(base_q) + SUM_W'(sol_q);

   rsf_frame_stack #(.DEPTH(SAVE_DEPTH), .W(FRM_W)) stack_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (stk_push),
      .pop       (stk_pop),
      .push_data (push_frame),
      .top_data  (top_frame),
      .full      (stk_full),
      .empty     (stk_empty)
   );

   always_comb begin
      base_d = base_q;
      sof_d  = sof_q;
      sol_d  = sol_q;
      held_d = held_q;
      err_d  = (do_alloc && !alloc_ok) || (do_call && stk_full) || (do_ret && stk_empty);
      if (do_alloc && alloc_ok) begin
         sof_d = req_total[CNT_W-1:0];
         sol_d = cmd_locals;
      end else if (stk_push) begin
         base_d = (call_sum >= SUM_W'(PHYS_STACKED))
                  ? BASE_W'(call_sum - SUM_W'(PHYS_STACKED)) : BASE_W'(call_sum);
         sof_d  = sof_q - sol_q;
         sol_d  = '0;
         held_d = held_q + HELD_W'(sol_q);
      end else if (stk_pop) begin
         base_d = pop_base;
         sof_d  = pop_sof;
         sol_d  = pop_sol;
         held_d = held_q - HELD_W'(pop_sol);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         sof_q  <= '0;
         sol_q  <= '0;
         held_q <= '0;
         err_q  <= 1'b0;
      end else begin
         base_q <= base_d;
         sof_q  <= sof_d;
         sol_q  <= sol_d;
         held_q <= held_d;
         err_q  <= err_d;
      end
   end

   rsf_map #(.PHYS(PHYS_STACKED), .BASE_W(BASE_W), .PREG_W(PREG_W)) map_i (
      .lreg    (rd_lreg),
      .base    (base_q),
      .sof     (sof_q),
      .preg    (rd_preg),
      .illegal (rd_illegal)
   );

   assign cur_base  = base_q;
   assign cur_sof   = sof_q;
   assign cur_sol   = sol_q;
   assign cmd_err   = err_q;
   assign spill_req = ((HELD_W+1)'(held_q) + (HELD_W+1)'(sof_q)) > (HELD_W+1)'(PHYS_STACKED);
endmodule

// File: rtl/rsf_renamer_chk.sv
module rsf_renamer_chk import rsf_pkg::*; #(
   parameter int unsigned BASE_W = 7,
   parameter int unsigned PREG_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic [CNT_W-1:0]  cmd_locals,
   input logic [CNT_W-1:0]  cmd_outs,
   input logic [LREG_W-1:0] rd_lreg,
   input logic [PREG_W-1:0] rd_preg,
   input logic              rd_illegal,
   input logic [BASE_W-1:0] cur_base,
   input logic [CNT_W-1:0]  cur_sof,
   input logic [CNT_W-1:0]  cur_sol,
   input logic              cmd_err
);
   AST_GLOBAL_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lreg < LREG_W'(GLOBAL_REGS)) |-> (rd_preg == PREG_W'(rd_lreg)) && !rd_illegal); // R1
   AST_STACKED_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lreg >= LREG_W'(GLOBAL_REGS)) |-> (rd_preg >= PREG_W'(GLOBAL_REGS))); // R2
   AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_sof <= CNT_W'(WINDOW_REGS)) && (cur_sol <= cur_sof)); // R4
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(cur_base) && $stable(cur_sof) && $stable(cur_sol)); // R4
   AST_ALLOC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'd1 &&
       ((CNT_W+1)'(cmd_locals) + (CNT_W+1)'(cmd_outs)) > (CNT_W+1)'(WINDOW_REGS))
      |=> cmd_err && $stable(cur_sof) && $stable(cur_sol)); // R5
   AST_CALL_CLEARS_LOCALS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'd2) |=> (cur_sol == '0) || cmd_err); // R6
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !cmd_err); // R11
endmodule

bind rsf_renamer rsf_renamer_chk #(.BASE_W(BASE_W), .PREG_W(PREG_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .cmd_locals (cmd_locals),
   .cmd_outs   (cmd_outs),
   .rd_lreg    (rd_lreg),
   .rd_preg    (rd_preg),
   .rd_illegal (rd_illegal),
   .cur_base   (cur_base),
   .cur_sof    (cur_sof),
   .cur_sol    (cur_sol),
   .cmd_err    (cmd_err)
);

// File: tb/rsf_renamer_tb.sv
`timescale 1ns/1ps
module rsf_renamer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [6:0] cmd_locals = '0, cmd_outs = '0, rd_lreg = '0;
   logic [6:0] rd_preg, cur_base, cur_sof, cur_sol;
   logic       rd_illegal, cmd_err, spill_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rsf_renamer dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_locals(cmd_locals), .cmd_outs(cmd_outs), .rd_lreg(rd_lreg),
      .rd_preg(rd_preg), .rd_illegal(rd_illegal), .cur_base(cur_base),
      .cur_sof(cur_sof), .cur_sol(cur_sol), .cmd_err(cmd_err), .spill_req(spill_req)
   );

   typedef struct packed {
      logic [1:0] op;
      logic [6:0] loc, outs, lreg, preg;
      logic       ill;
      logic [6:0] base, sof, sol;
      logic       err, spill;
      logic [7:0] req;
   } vec_t;

   // op, locals, outs, lreg | preg, illegal, base, sof, sol, err, spill, requirement
   localparam vec_t VEC [14] = '{
      '{2'd1, 7'd10, 7'd5,  7'd32,  7'd32,  1'b0, 7'd0,  7'd15, 7'd10, 1'b0, 1'b0, 8'd4},  // R4 allocate
      '{2'd0, 7'd0,  7'd0,  7'd46,  7'd46,  1'b0, 7'd0,  7'd15, 7'd10, 1'b0, 1'b0, 8'd3},  // R3 last in frame
      '{2'd0, 7'd0,  7'd0,  7'd47,  7'd47,  1'b1, 7'd0,  7'd15, 7'd10, 1'b0, 1'b0, 8'd3},  // R3 first beyond frame
      '{2'd0, 7'd0,  7'd0,  7'd5,   7'd5,   1'b0, 7'd0,  7'd15, 7'd10, 1'b0, 1'b0, 8'd1},  // R1 global
      '{2'd2, 7'd0,  7'd0,  7'd32,  7'd42,  1'b0, 7'd10, 7'd5,  7'd0,  1'b0, 1'b0, 8'd6},  // R6 call
      '{2'd1, 7'd50, 7'd40, 7'd127, 7'd41,  1'b1, 7'd10, 7'd90, 7'd50, 1'b0, 1'b1, 8'd9},  // R9 spill
      '{2'd0, 7'd0,  7'd0,  7'd121, 7'd35,  1'b0, 7'd10, 7'd90, 7'd50, 1'b0, 1'b1, 8'd2},  // R2 wrap
      '{2'd1, 7'd60, 7'd37, 7'd32,  7'd42,  1'b0, 7'd10, 7'd90, 7'd50, 1'b1, 1'b1, 8'd5},  // R5 reject 97
      '{2'd2, 7'd0,  7'd0,  7'd32,  7'd92,  1'b0, 7'd60, 7'd40, 7'd0,  1'b0, 1'b1, 8'd11}, // R11 pulse ends, R6
      '{2'd1, 7'd96, 7'd0,  7'd127, 7'd91,  1'b0, 7'd60, 7'd96, 7'd96, 1'b0, 1'b1, 8'd5},  // R5 accept 96
      '{2'd3, 7'd0,  7'd0,  7'd32,  7'd42,  1'b0, 7'd10, 7'd90, 7'd50, 1'b0, 1'b1, 8'd7},  // R7 return
      '{2'd3, 7'd0,  7'd0,  7'd32,  7'd32,  1'b0, 7'd0,  7'd15, 7'd10, 1'b0, 1'b0, 8'd7},  // R7 return
      '{2'd3, 7'd0,  7'd0,  7'd32,  7'd32,  1'b0, 7'd0,  7'd15, 7'd10, 1'b1, 1'b0, 8'd7},  // R7 empty
      '{2'd1, 7'd0,  7'd0,  7'd32,  7'd32,  1'b1, 7'd0,  7'd0,  7'd0,  1'b0, 1'b0, 8'd3}   // R3 empty frame
   };

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic cmd(input logic [1:0] op, input logic [6:0] l, input logic [6:0] o);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_locals = l; cmd_outs = o;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic state_chk(input string tag, input int b, input int f, input int s);
      chk(tag, "base", int'(cur_base), b);
      chk(tag, "sof", int'(cur_sof), f);
      chk(tag, "sol", int'(cur_sol), s);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      rd_lreg = 7'd32;
      @(negedge clk);
      state_chk("R10", 0, 0, 0);
      chk("R10", "cmd_err", int'(cmd_err), 0);
      chk("R10", "spill_req", int'(spill_req), 0);
      chk("R3", "illegal empty", int'(rd_illegal), 1);

      // vector table
      foreach (VEC[i]) begin
         cmd_valid = 1'b1; cmd_op = VEC[i].op;
         cmd_locals = VEC[i].loc; cmd_outs = VEC[i].outs; rd_lreg = VEC[i].lreg;
         @(negedge clk);
         begin
            string tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            chk(tag, "preg", int'(rd_preg), int'(VEC[i].preg));
            chk(tag, "illegal", int'(rd_illegal), int'(VEC[i].ill));
            state_chk(tag, int'(VEC[i].base), int'(VEC[i].sof), int'(VEC[i].sol));
            chk(tag, "cmd_err", int'(cmd_err), int'(VEC[i].err));
            chk(tag, "spill_req", int'(spill_req), int'(VEC[i].spill));
         end
      end
      cmd_valid = 1'b0;

      // R1 highest global
      rd_lreg = 7'd31;
      #1 chk("R1", "preg 31", int'(rd_preg), 31);
      chk("R1", "illegal 31", int'(rd_illegal), 0);

      // R4 command ignored while cmd_valid low
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'd1; cmd_locals = 7'd5; cmd_outs = 7'd5;
      @(negedge clk);
      state_chk("R4 idle", 0, 0, 0);
      chk("R11", "no err idle", int'(cmd_err), 0);

      // R8 saved-frame stack full
      for (int k = 0; k < 4; k++) begin
         cmd(2'd1, 7'd2, 7'd2);
         cmd(2'd2, 7'd0, 7'd0);
      end
      state_chk("R6 chain", 8, 2, 0);
      cmd(2'd1, 7'd2, 7'd2);
      cmd(2'd2, 7'd0, 7'd0);
      chk("R8", "cmd_err", int'(cmd_err), 1);
      state_chk("R8", 8, 4, 2);
      rd_lreg = 7'd33;
      #1 chk("R2", "preg base8", int'(rd_preg), 41);
      @(negedge clk);
      chk("R11", "err cleared", int'(cmd_err), 0);

      // R10 reset from a busy state
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      state_chk("R10 rerst", 0, 0, 0);
      chk("R10", "spill after reset", int'(spill_req), 0);
      cmd(2'd3, 7'd0, 7'd0);
      chk("R7", "empty after reset", int'(cmd_err), 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule